// File: doc/BRIEF.md
# Chainable Event Counter Unit

A small bank of 64-bit event counters, each fed by its own one-cycle event pulse. Software configures each counter through a configuration register and a control register. The counter advances by one for every pulse while it is enabled and keeps its value while it is disabled or paused. Each counter records the overflow of its low half and the wrap of the whole counter in sticky status bits. It can drive a shared interrupt line, and it can emit a trigger pulse once every power-of-two number of counted events. A counter can also stop itself when a chosen set of counters wraps, so that one counter's overflow freezes a group of others for inspection.

Each counter holds its run state in a three-state machine with the states OFF, RUN and HOLD. The transitions are: start (OFF or HOLD to RUN, by a control write), hold (RUN or OFF to HOLD, by a control write), stop (any state to OFF, by a control write) and chain pause (RUN to HOLD, when a selected counter wraps). A global register can force one run state onto every counter without changing their stored states. Registers are written through a single-cycle write strobe and read combinationally through a separate read address.

Top module: `evc_unit`

## Requirements
- R1: After reset every counter value, configuration, control and status register reads 0, the global register reads 0, and `irq_o` and `trig_o` are 0.
- R2: A register address is {counter index, 3-bit select} with select 0 = config, 1 = control, 2 = value low half, 3 = value high half, 4 = status, 7 = global (any index). The control register's bits [1:0] hold the run state: 0 = OFF, 1 = RUN, 3 = HOLD; a written code 2 is stored and read back as 0. A counter adds one for each cycle in which its `evt_i` bit is 1 and its effective state is RUN.
- R3: A counter in HOLD keeps its value without clearing it, and resumes from that value once returned to RUN.
- R4: When global bit 0 is 1, every counter's effective state is the state coded in global bits [2:1] (same codes as R2) instead of its own control state; when global bit 0 is 0, each counter follows its own control register.
- R5: A counted event that carries out of low-half bit 31 increments the high half; it sets status bit 0 only when config bit 1 is 1.
- R6: A counted event that wraps all 64 bits to zero sets status bit 1 only when config bit 2 is 1.
- R7: Status bits stay set until a write of 1 to that bit of the status register; writing 0 leaves them; a set and a clearing write in the same cycle leave the bit set.
- R8: `irq_o` is 1 exactly when some counter has config bit 0 set and at least one of its status bits set.
- R9: With config bit 3 set, the counter's `trig_o` bit is high for one cycle after every P-th counted event, where config bits [7:4] hold code n and P = 1 for n = 0 and P = 2^(n-1) otherwise; with config bit 3 clear it stays 0.
- R10: Writing either value half loads that half, restarts the trigger sub-count, and takes priority over an event in the same cycle, which is then not counted.
- R11: Config bit 16+j set for counter i makes counter i, when in RUN, move to HOLD (control reads 3) in the cycle after counter j wraps all 64 bits, this counter included; an event arriving in the cycle the pause takes effect is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_CNT | One-cycle event pulse per counter |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | IDX_W+3 | Write address {index, select} |
| wr_data_i | input | REG_W | Write data |
| rd_addr_i | input | IDX_W+3 | Read address {index, select} |
| rd_data_o | output | REG_W | Read data, combinational |
| irq_o | output | 1 | Overflow interrupt |
| trig_o | output | NUM_CNT | Granule trigger pulse per counter |

## Verification
A wrong run state shows up on the very next event as a value that moved when it should have held, or held when it should have moved, and the control readback exposes it in the same cycle. A corrupted trigger sub-count shifts the trigger pulse away from the P-th event, so it is caught within one granule period. A status bit lost or set by mistake changes `irq_o` from the cycle after the edge, and a missed chain pause shows as one extra count on the sibling in the second back-to-back event.

// File: rtl/evc_pkg.sv
package evc_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd3
    } run_state_e;

    typedef enum logic [2:0] {
        SEL_CFG  = 3'd0,
        SEL_CTRL = 3'd1,
        SEL_VLO  = 3'd2,
        SEL_VHI  = 3'd3,
        SEL_STAT = 3'd4,
        SEL_GLB  = 3'd7
    } reg_sel_e;

    function automatic run_state_e decode_state(input logic [1:0] code);
        case (code)
            2'd1:    return ST_RUN;
            2'd3:    return ST_HOLD;
            default: return ST_OFF;
        endcase
    endfunction

endpackage

// File: rtl/evc_granule.sv
module evc_granule #(
    parameter int GRAN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              clr_i,
    input  logic [GRAN_W-1:0] code_i,
    output logic              trig_o
);
    localparam int SUB_W = (1 << GRAN_W) - 1;

    logic [SUB_W-1:0] sub_q;
    logic [SUB_W-1:0] last_val;
    logic             trig_q;

    // Last sub-count value of one granule period.
    always_comb begin
        if (code_i == '0) begin
            last_val = '0;
        end else begin
            last_val = (SUB_W'(1) << (code_i - GRAN_W'(1))) - SUB_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            sub_q  <= '0;
            trig_q <= 1'b0;
        end else if (tick_i) begin
            if (sub_q == last_val) begin
                sub_q  <= '0;
                trig_q <= 1'b1;
            end else begin
                sub_q  <= sub_q + SUB_W'(1);
                trig_q <= 1'b0;
            end
        end else begin
            trig_q <= 1'b0;
        end
    end

    assign trig_o = trig_q;

endmodule

// File: rtl/evc_counter.sv
module evc_counter
    import evc_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int GRAN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_i,
    input  logic              ovr_i,
    input  run_state_e        ovr_state_i,
    input  logic              ctrl_we_i,
    input  logic [1:0]        ctrl_code_i,
    input  logic              chain_hit_i,
    input  logic              lo_we_i,
    input  logic              hi_we_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic [1:0]        stat_clr_i,
    input  logic              lo_en_i,
    input  logic              hi_en_i,
    input  logic              trig_en_i,
    input  logic [GRAN_W-1:0] gran_i,
    output run_state_e        state_o,
    output logic [2*REG_W-1:0] value_o,
    output logic [1:0]        stat_o,
    output logic              fire_o,
    output logic              wrap_o,
    output logic              trig_o
);
    run_state_e       state_q, state_d, eff_state;
    logic [REG_W-1:0] lo_q, hi_q;
    logic             lo_st_q, hi_st_q;
    logic             fire, lo_carry, wrap;

    // Next-state logic: chain pause wins over a control write.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (ctrl_we_i) state_d = decode_state(ctrl_code_i);
            end
            ST_RUN: begin
                if (chain_hit_i)    state_d = ST_HOLD;
                else if (ctrl_we_i) state_d = decode_state(ctrl_code_i);
            end
            ST_HOLD: begin
                if (ctrl_we_i) state_d = decode_state(ctrl_code_i);
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    assign eff_state = ovr_i ? ovr_state_i : state_q;
    assign fire      = evt_i && (eff_state == ST_RUN) && !lo_we_i && !hi_we_i;
    assign lo_carry  = fire && (&lo_q);
    assign wrap      = lo_carry && (&hi_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q    <= '0;
            hi_q    <= '0;
            lo_st_q <= 1'b0;
            hi_st_q <= 1'b0;
        end else begin
            if (lo_we_i)   lo_q <= wdata_i;
            else if (fire) lo_q <= lo_q + REG_W'(1);
            if (hi_we_i)       hi_q <= wdata_i;
            else if (lo_carry) hi_q <= hi_q + REG_W'(1);
            lo_st_q <= (lo_st_q && !stat_clr_i[0]) || (lo_carry && lo_en_i);
            hi_st_q <= (hi_st_q && !stat_clr_i[1]) || (wrap && hi_en_i);
        end
    end

    evc_granule #(.GRAN_W(GRAN_W)) gran_i_u (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (fire && trig_en_i),
        .clr_i  (lo_we_i || hi_we_i),
        .code_i (gran_i),
        .trig_o (trig_o)
    );

    // Output process.
    always_comb begin
        state_o = state_q;
        value_o = {hi_q, lo_q};
        stat_o  = {hi_st_q, lo_st_q};
        fire_o  = fire;
        wrap_o  = wrap;
    end

endmodule

// File: rtl/evc_unit.sv
module evc_unit
    import evc_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int REG_W   = 32,
    parameter int GRAN_W  = 4,
    localparam int IDX_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1,
    localparam int ADDR_W = IDX_W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] evt_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [REG_W-1:0]   wr_data_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [REG_W-1:0]   rd_data_o,
    output logic               irq_o,
    output logic [NUM_CNT-1:0] trig_o
);
    localparam int MASK_LSB = 16;
    localparam int GRAN_LSB = 4;

    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [2:0]       wr_sel, rd_sel;

    logic [NUM_CNT-1:0]              irq_en_q, lo_en_q, hi_en_q, trig_en_q;
    logic [NUM_CNT-1:0][GRAN_W-1:0]  gran_q;
    logic [NUM_CNT-1:0][NUM_CNT-1:0] mask_v;
    logic                            glb_ovr_q;
    logic [1:0]                      glb_code_q;

    logic [NUM_CNT-1:0][1:0]         state_v;
    logic [NUM_CNT-1:0][2*REG_W-1:0] val_v;
    logic [NUM_CNT-1:0]              lo_st_v, hi_st_v, fire_v, wrap_v;

    assign wr_idx = wr_addr_i[ADDR_W-1:3];
    assign wr_sel = wr_addr_i[2:0];
    assign rd_idx = rd_addr_i[ADDR_W-1:3];
    assign rd_sel = rd_addr_i[2:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_ovr_q  <= 1'b0;
            glb_code_q <= 2'd0;
        end else if (wr_en_i && wr_sel == SEL_GLB) begin
            glb_ovr_q  <= wr_data_i[0];
            glb_code_q <= wr_data_i[2:1];
        end
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic       hit;
        run_state_e st;
        logic [1:0] stat;

        assign hit = wr_en_i && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irq_en_q[i]  <= 1'b0;
                lo_en_q[i]   <= 1'b0;
                hi_en_q[i]   <= 1'b0;
                trig_en_q[i] <= 1'b0;
                gran_q[i]    <= '0;
                mask_v[i]    <= '0;
            end else if (hit && wr_sel == SEL_CFG) begin
                irq_en_q[i]  <= wr_data_i[0];
                lo_en_q[i]   <= wr_data_i[1];
                hi_en_q[i]   <= wr_data_i[2];
                trig_en_q[i] <= wr_data_i[3];
                gran_q[i]    <= wr_data_i[GRAN_LSB +: GRAN_W];
                mask_v[i]    <= wr_data_i[MASK_LSB +: NUM_CNT];
            end
        end

        evc_counter #(.REG_W(REG_W), .GRAN_W(GRAN_W)) cnt_u (
            .clk         (clk),
            .rst_n       (rst_n),
            .evt_i       (evt_i[i]),
            .ovr_i       (glb_ovr_q),
            .ovr_state_i (decode_state(glb_code_q)),
            .ctrl_we_i   (hit && wr_sel == SEL_CTRL),
            .ctrl_code_i (wr_data_i[1:0]),
            .chain_hit_i (|(wrap_v & mask_v[i])),
            .lo_we_i     (hit && wr_sel == SEL_VLO),
            .hi_we_i     (hit && wr_sel == SEL_VHI),
            .wdata_i     (wr_data_i),
            .stat_clr_i  ((hit && wr_sel == SEL_STAT) ? wr_data_i[1:0] : 2'b00),
            .lo_en_i     (lo_en_q[i]),
            .hi_en_i     (hi_en_q[i]),
            .trig_en_i   (trig_en_q[i]),
            .gran_i      (gran_q[i]),
            .state_o     (st),
            .value_o     (val_v[i]),
            .stat_o      (stat),
            .fire_o      (fire_v[i]),
            .wrap_o      (wrap_v[i]),
            .trig_o      (trig_o[i])
        );

        assign state_v[i] = st;
        assign lo_st_v[i] = stat[0];
        assign hi_st_v[i] = stat[1];
    end

    assign irq_o = |(irq_en_q & (lo_st_v | hi_st_v));

    always_comb begin
        rd_data_o = '0;
        case (rd_sel)
            SEL_CFG: begin
                rd_data_o = (REG_W'(mask_v[rd_idx]) << MASK_LSB)
                          | (REG_W'(gran_q[rd_idx]) << GRAN_LSB)
                          | REG_W'({trig_en_q[rd_idx], hi_en_q[rd_idx],
                                    lo_en_q[rd_idx], irq_en_q[rd_idx]});
            end
            SEL_CTRL: rd_data_o = REG_W'(state_v[rd_idx]);
            SEL_VLO:  rd_data_o = val_v[rd_idx][REG_W-1:0];
            SEL_VHI:  rd_data_o = val_v[rd_idx][2*REG_W-1:REG_W];
            SEL_STAT: rd_data_o = REG_W'({hi_st_v[rd_idx], lo_st_v[rd_idx]});
            SEL_GLB:  rd_data_o = REG_W'({glb_code_q, glb_ovr_q});
            default:  rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/evc_unit_chk.sv
module evc_unit_chk #(
    parameter int NUM_CNT = 4,
    parameter int ADDR_W  = 5
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            irq_o,
    input logic [NUM_CNT-1:0]              trig_o,
    input logic                            wr_en_i,
    input logic [ADDR_W-1:0]               wr_addr_i,
    input logic                            glb_ovr_q,
    input logic [NUM_CNT-1:0][1:0]         state_v,
    input logic [NUM_CNT-1:0][NUM_CNT-1:0] mask_v,
    input logic [NUM_CNT-1:0]              lo_st_v,
    input logic [NUM_CNT-1:0]              hi_st_v,
    input logic [NUM_CNT-1:0]              fire_v,
    input logic [NUM_CNT-1:0]              wrap_v
);
    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|(lo_st_v | hi_st_v)));

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
        logic stat_wr;
        assign stat_wr = wr_en_i && (wr_addr_i == ADDR_W'((i << 3) | 4));

        assert_trig_after_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
            trig_o[i] |-> $past(fire_v[i]));

        assert_hold_no_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!glb_ovr_q && state_v[i] == 2'd3) |-> !fire_v[i]);

        assert_chain_pause_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (state_v[i] == 2'd1 && (|(wrap_v & mask_v[i]))) |=> (state_v[i] == 2'd3));

        assert_lo_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (lo_st_v[i] && !stat_wr) |=> lo_st_v[i]);

        assert_hi_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (hi_st_v[i] && !stat_wr) |=> hi_st_v[i]);

        assert_wrap_counted_R6: assert property (@(posedge clk) disable iff (!rst_n)
            wrap_v[i] |-> fire_v[i]);
    end
endmodule

bind evc_unit evc_unit_chk #(.NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_o     (irq_o),
    .trig_o    (trig_o),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .glb_ovr_q (glb_ovr_q),
    .state_v   (state_v),
    .mask_v    (mask_v),
    .lo_st_v   (lo_st_v),
    .hi_st_v   (hi_st_v),
    .fire_v    (fire_v),
    .wrap_v    (wrap_v)
);

// File: tb/evc_unit_tb_top.sv
`timescale 1ns/1ps
module evc_unit_tb_top;
    localparam int N  = 4;
    localparam int AW = 5;
    localparam int S_CFG = 0, S_CTRL = 1, S_VLO = 2, S_VHI = 3, S_STAT = 4, S_GLB = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  evt = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic          irq;
    logic [N-1:0]  trig;

    int n_chk = 0;
    int n_err = 0;
    int trig_cnt [N];
    bit done = 0;

    always #10 clk = ~clk;

    evc_unit #(.NUM_CNT(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .irq_o(irq), .trig_o(trig)
    );

    function automatic logic [AW-1:0] adr(int idx, int sel);
        return AW'((idx << 3) | sel);
    endfunction

    function automatic int run_of(int code);
        return (code == 1) ? 1 : ((code == 3) ? 3 : 0);
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(int idx, int sel, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = adr(idx, sel); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int idx, int sel, output logic [31:0] d);
        rd_addr = adr(idx, sel);
        #1;
        d = rd_data;
    endtask

    task automatic sample_trig();
        for (int i = 0; i < N; i++) trig_cnt[i] += int'(trig[i]);
    endtask

    task automatic pulse(logic [N-1:0] m);
        @(negedge clk);
        evt = m;
        @(negedge clk);
        evt = '0;
        sample_trig();
    endtask

    task automatic pulse2(logic [N-1:0] m);
        @(negedge clk);
        evt = m;
        @(negedge clk);
        sample_trig();
        @(negedge clk);
        evt = '0;
        sample_trig();
    endtask

    task automatic clr_trig();
        for (int i = 0; i < N; i++) trig_cnt[i] = 0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int cnt_m [N];
        int st_m [N];
        void'($urandom(32'd2718));
        clr_trig();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < N; i++) begin
            rd(i, S_CFG, d);  chk("R1 cfg", d, 0);
            rd(i, S_CTRL, d); chk("R1 ctrl", d, 0);
            rd(i, S_VLO, d);  chk("R1 vlo", d, 0);
            rd(i, S_VHI, d);  chk("R1 vhi", d, 0);
            rd(i, S_STAT, d); chk("R1 stat", d, 0);
        end
        rd(0, S_GLB, d); chk("R1 glb", d, 0);
        chk("R1 irq", irq, 0);
        chk("R1 trig", trig, 0);

        // R2 counting only in RUN, code 2 reads as 0
        wr(0, S_CTRL, 1);
        repeat (5) pulse(4'b0011);
        rd(0, S_VLO, d); chk("R2 run count", d, 5);
        rd(1, S_VLO, d); chk("R2 off no count", d, 0);
        wr(1, S_CTRL, 2);
        rd(1, S_CTRL, d); chk("R2 code2 reads 0", d, 0);
        pulse(4'b0010);
        rd(1, S_VLO, d); chk("R2 code2 no count", d, 0);

        // R3 hold keeps value and resumes
        wr(0, S_CTRL, 3);
        rd(0, S_CTRL, d); chk("R3 ctrl hold", d, 3);
        repeat (3) pulse(4'b0001);
        rd(0, S_VLO, d); chk("R3 held", d, 5);
        wr(0, S_CTRL, 1);
        pulse(4'b0001);
        rd(0, S_VLO, d); chk("R3 resumed", d, 6);

        // R4 global override
        wr(0, S_GLB, 32'h3);
        repeat (2) pulse(4'b0010);
        rd(1, S_VLO, d); chk("R4 forced run", d, 2);
        wr(0, S_GLB, 32'h7);
        pulse(4'b0001);
        rd(0, S_VLO, d); chk("R4 forced hold", d, 6);
        wr(0, S_GLB, 32'h0);
        pulse(4'b0011);
        rd(0, S_VLO, d); chk("R4 own state c0", d, 7);
        rd(1, S_VLO, d); chk("R4 own state c1", d, 2);

        // R5 low-half carry and its status enable
        wr(2, S_CFG, 32'h2);
        wr(2, S_VLO, 32'hFFFF_FFFF);
        wr(2, S_CTRL, 1);
        pulse(4'b0100);
        rd(2, S_VLO, d); chk("R5 lo wraps", d, 0);
        rd(2, S_VHI, d); chk("R5 carry to hi", d, 1);
        rd(2, S_STAT, d); chk("R5 lo status set", d, 1);
        wr(3, S_VLO, 32'hFFFF_FFFF);
        wr(3, S_CTRL, 1);
        pulse(4'b1000);
        rd(3, S_VHI, d); chk("R5 carry c3", d, 1);
        rd(3, S_STAT, d); chk("R5 lo status gated", d, 0);

        // R8 interrupt gating
        chk("R8 irq off when disabled", irq, 0);
        wr(2, S_CFG, 32'h3);
        chk("R8 irq on", irq, 1);

        // R7 write-one-to-clear
        wr(2, S_STAT, 32'h0);
        rd(2, S_STAT, d); chk("R7 write0 keeps", d, 1);
        chk("R7 irq kept", irq, 1);
        wr(2, S_STAT, 32'h1);
        rd(2, S_STAT, d); chk("R7 write1 clears", d, 0);
        chk("R8 irq drops", irq, 0);

        // R6 full wrap and its status enable
        wr(3, S_CFG, 32'h4);
        wr(3, S_VLO, 32'hFFFF_FFFF);
        wr(3, S_VHI, 32'hFFFF_FFFF);
        pulse(4'b1000);
        rd(3, S_VLO, d); chk("R6 wrap lo", d, 0);
        rd(3, S_VHI, d); chk("R6 wrap hi", d, 0);
        rd(3, S_STAT, d); chk("R6 hi status only", d, 2);

        // R7 set wins over clear in the same cycle
        wr(3, S_VLO, 32'hFFFF_FFFF);
        wr(3, S_VHI, 32'hFFFF_FFFF);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = adr(3, S_STAT); wr_data = 32'h3; evt = 4'b1000;
        @(negedge clk);
        wr_en = 1'b0; evt = '0;
        rd(3, S_STAT, d); chk("R7 set wins", d, 2);

        // R9 trigger granule
        wr(1, S_CTRL, 1);
        wr(1, S_CFG, 32'h8);
        clr_trig();
        repeat (3) pulse(4'b0010);
        chk("R9 code0 every event", trig_cnt[1], 3);
        wr(1, S_CFG, 32'h38);
        clr_trig();
        repeat (3) pulse(4'b0010);
        chk("R9 code3 not yet", trig_cnt[1], 0);
        pulse(4'b0010);
        chk("R9 code3 fourth", trig_cnt[1], 1);
        repeat (4) pulse(4'b0010);
        chk("R9 code3 eighth", trig_cnt[1], 2);
        wr(1, S_CFG, 32'h0);
        clr_trig();
        repeat (2) pulse(4'b0010);
        chk("R9 disabled", trig_cnt[1], 0);

        // R10 value write restarts sub-count and wins over event
        wr(1, S_CFG, 32'h38);
        clr_trig();
        repeat (2) pulse(4'b0010);
        wr(1, S_VLO, 32'd100);
        rd(1, S_VLO, d); chk("R10 load", d, 100);
        repeat (3) pulse(4'b0010);
        chk("R10 sub restarted", trig_cnt[1], 0);
        pulse(4'b0010);
        chk("R10 trig after restart", trig_cnt[1], 1);
        rd(1, S_VLO, d); chk("R10 count after load", d, 104);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = adr(1, S_VLO); wr_data = 32'd500; evt = 4'b0010;
        @(negedge clk);
        wr_en = 1'b0; evt = '0;
        rd(1, S_VLO, d); chk("R10 write wins", d, 500);

        // R11 chain pause from a sibling
        wr(1, S_CFG, 32'h1_0000);
        wr(0, S_CFG, 32'h0);
        wr(0, S_VLO, 32'hFFFF_FFFF);
        wr(0, S_VHI, 32'hFFFF_FFFF);
        pulse2(4'b0011);
        rd(0, S_VLO, d); chk("R11 source keeps counting", d, 1);
        rd(0, S_VHI, d); chk("R11 source hi", d, 0);
        rd(1, S_VLO, d); chk("R11 sibling paused", d, 501);
        rd(1, S_CTRL, d); chk("R11 sibling ctrl hold", d, 3);
        rd(0, S_CTRL, d); chk("R11 source still run", d, 1);
        // R11 self pause, unmasked counter unaffected
        wr(0, S_CFG, 32'h1_0000);
        wr(0, S_VLO, 32'hFFFF_FFFF);
        wr(0, S_VHI, 32'hFFFF_FFFF);
        wr(2, S_VLO, 32'h0);
        pulse2(4'b0101);
        rd(0, S_VLO, d); chk("R11 self held at 0", d, 0);
        rd(0, S_CTRL, d); chk("R11 self ctrl hold", d, 3);
        rd(2, S_VLO, d); chk("R11 unmasked counts", d, 2);

        // R2 R3 random phase
        for (int i = 0; i < N; i++) begin
            wr(i, S_CFG, 0); wr(i, S_CTRL, 0);
            wr(i, S_VLO, 0); wr(i, S_VHI, 0); wr(i, S_STAT, 3);
            cnt_m[i] = 0; st_m[i] = 0;
        end
        for (int it = 0; it < 300; it++) begin
            if ($urandom % 4 == 0) begin
                int idx = int'($urandom % N);
                int code = int'($urandom % 4);
                wr(idx, S_CTRL, 32'(code));
                st_m[idx] = run_of(code);
            end else begin
                logic [N-1:0] m = N'($urandom);
                pulse(m);
                for (int i = 0; i < N; i++)
                    if (m[i] && st_m[i] == 1) cnt_m[i]++;
            end
            if (it % 50 == 49) begin
                for (int i = 0; i < N; i++) begin
                    rd(i, S_VLO, d); chk("R2 random count", d, 64'(cnt_m[i]));
                    rd(i, S_CTRL, d); chk("R3 random state", d, 64'(st_m[i]));
                end
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule